// File: doc/BRIEF.md
# Trigger Final Decision Logic

This block turns a vector of per-crossing algorithm bits into one global accept. It makes one decision on every bunch-crossing clock, nominally 40 MHz. Each algorithm bit first passes through its own prescaler. The prescaled bits are then gated by a software-loaded final-OR mask and ORed together. Separately, any raw algorithm bit that is flagged in a veto mask suppresses the accept for that crossing. The result is registered, so the accept appears exactly one clock after the crossing it belongs to.

Every algorithm bit also has its own saturating trigger counter. A counter counts raw occurrences of its bit, before prescaling and regardless of the mask. Software sets the masks and prescale factors and clears the counters through a single-cycle register-write port, so no logic has to be rebuilt. A select input reads out any one counter combinationally. The number of algorithm bits, the prescale factor width and the counter width are all parameters. The baseline is 128 algorithm bits.

Top module: `trig_final_decision`

## Requirements
- R1: After reset, `accept` is low, every counter reads zero, the final-OR and veto masks are all clear, and every prescale factor is 1. Internal reset is released two clock edges after `rst_n` rises.
- R2: `accept` is registered. Its value in the cycle after clock edge k depends only on `algo_bits` and the configuration sampled at edge k. With no algorithm bit set at an edge, `accept` is low after that edge.
- R3: Only prescaled bits whose final-OR mask bit is set can raise `accept`. A write with `cfg_addr[top two bits]` = 0 loads mask word w = `cfg_addr` low bits. Bit j of `cfg_wdata` in that word controls algorithm bit 32*w + j.
- R4: If any raw algorithm bit with its veto bit set is high at an edge, `accept` is low after that edge. This holds whatever that bit's mask or prescale factor is. Veto words are written at region 1, with the same word/bit layout as the mask.
- R5: With prescale factor N >= 1, bit i passes on its Nth, 2Nth, 3Nth... occurrence, counted since reset or since the last write of its factor. Cycles where the bit is low do not advance the count. Factors are written at region 2: the low address bits give i and `cfg_wdata[PS_W-1:0]` gives N.
- R6: A prescale factor of 0 stops its bit from ever contributing to `accept`.
- R7: Counter i increments on every edge at which `algo_bits[i]` is high. This happens independently of that bit's mask and prescale factor.
- R8: A counter that has reached its all-ones value stays there.
- R9: Any write to region 3 clears all counters at that edge. The clear wins over an occurrence at the same edge.
- R10: `cnt_value` shows the counter chosen by `cnt_sel` without a clock delay. A select at or beyond the number of algorithm bits reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| algo_bits | input | N_ALGO | Algorithm bits for the current crossing |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | IDX_W+2 | Top two bits give the region (0 mask, 1 veto, 2 prescale, 3 clear); low bits give the word or bit index |
| cfg_wdata | input | 32 | Write data |
| cnt_sel | input | IDX_W | Index of the counter to read |
| cnt_value | output | CNT_W | Selected counter value |
| accept | output | 1 | Registered global accept |

## Verification
The bench builds the block with 40 algorithm bits, 4-bit prescale factors and 4-bit counters. The 40-bit width makes the second mask and veto word only partly filled, so the word/bit layout is tested across a word boundary. The 4-bit counters saturate after fifteen occurrences, which brings R8 within a short run. The small factor width keeps prescale sequences of 2 and 3 cheap to walk, including rewriting a factor partway through a count.

// File: rtl/trig_fdl_pkg.sv
package trig_fdl_pkg;

  localparam int CFG_DW   = 32;
  localparam int WORD_SH  = 5;

  typedef enum logic [1:0] {
    REG_MASK     = 2'd0,
    REG_VETO     = 2'd1,
    REG_PRESCALE = 2'd2,
    REG_CLEAR    = 2'd3
  } cfg_region_e;

endpackage

// File: rtl/fdl_prescaler.sv
module fdl_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_i,
  input  logic [PS_W-1:0] factor_i,
  input  logic            load_i,
  output logic            pass_o
);

  logic [PS_W-1:0] count_q;
  logic [PS_W-1:0] count_d;
  logic            count_en;
  logic            active;
  logic            at_term;

  // factor 0 disables the bit entirely
  assign active  = (factor_i != '0);
  assign at_term = (count_q == (factor_i - PS_W'(1)));
  assign pass_o  = hit_i & active & at_term;

  always_comb begin
    count_en = load_i | (hit_i & active);
    count_d  = count_q;
    if (load_i) begin
      count_d = '0;
    end else if (hit_i && active) begin
      count_d = at_term ? '0 : count_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/fdl_counter.sv
module fdl_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             full;

  assign full    = &cnt_q;
  assign count_o = cnt_q;

  always_comb begin
    cnt_en = clr_i | (hit_i & ~full);
    cnt_d  = clr_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fdl_cfg_regs.sv
module fdl_cfg_regs
  import trig_fdl_pkg::*;
#(
  parameter int N_ALGO = 128,
  parameter int PS_W   = 8,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic [CFG_DW-1:0]            cfg_wdata,
  output logic [N_ALGO-1:0]            mask_o,
  output logic [N_ALGO-1:0]            veto_o,
  output logic [N_ALGO-1:0][PS_W-1:0]  factor_o,
  output logic [N_ALGO-1:0]            ps_load_o,
  output logic                         cnt_clr_o
);

  cfg_region_e              region;
  logic [IDX_W-1:0]         idx;
  logic [N_ALGO-1:0]        mask_q,   mask_d;
  logic [N_ALGO-1:0]        veto_q,   veto_d;
  logic [N_ALGO-1:0][PS_W-1:0] factor_q, factor_d;

  assign region = cfg_region_e'(cfg_addr[ADDR_W-1 -: 2]);
  assign idx    = cfg_addr[IDX_W-1:0];

  always_comb begin
    mask_d    = mask_q;
    veto_d    = veto_q;
    factor_d  = factor_q;
    ps_load_o = '0;
    cnt_clr_o = 1'b0;
    if (cfg_we) begin
      unique case (region)
        REG_MASK: begin
          for (int i = 0; i < N_ALGO; i++) begin
            if (IDX_W'(i >> WORD_SH) == idx) mask_d[i] = cfg_wdata[i % CFG_DW];
          end
        end
        REG_VETO: begin
          for (int i = 0; i < N_ALGO; i++) begin
            if (IDX_W'(i >> WORD_SH) == idx) veto_d[i] = cfg_wdata[i % CFG_DW];
          end
        end
        REG_PRESCALE: begin
          for (int i = 0; i < N_ALGO; i++) begin
            if (IDX_W'(i) == idx) begin
              factor_d[i]  = cfg_wdata[PS_W-1:0];
              ps_load_o[i] = 1'b1;
            end
          end
        end
        REG_CLEAR: cnt_clr_o = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      veto_q   <= '0;
      factor_q <= {N_ALGO{PS_W'(1)}};
    end else if (cfg_we) begin
      mask_q   <= mask_d;
      veto_q   <= veto_d;
      factor_q <= factor_d;
    end
  end

  assign mask_o   = mask_q;
  assign veto_o   = veto_q;
  assign factor_o = factor_q;

endmodule

// File: rtl/trig_final_decision.sv
module trig_final_decision
  import trig_fdl_pkg::*;
#(
  parameter  int N_ALGO = 128,
  parameter  int PS_W   = 8,
  parameter  int CNT_W  = 16,
  localparam int IDX_W  = $clog2(N_ALGO),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ALGO-1:0] algo_bits,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  cnt_sel,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              accept
);

  logic [1:0]                  rst_sync_q;
  logic                        rst_sync_n;
  logic [N_ALGO-1:0]           mask_w;
  logic [N_ALGO-1:0]           veto_w;
  logic [N_ALGO-1:0][PS_W-1:0] factor_w;
  logic [N_ALGO-1:0]           ps_load_w;
  logic                        cnt_clr_w;
  logic [N_ALGO-1:0]           pass_w;
  logic [N_ALGO-1:0][CNT_W-1:0] cnt_w;
  logic                        or_hit;
  logic                        veto_hit;
  logic                        accept_d;
  logic                        accept_q;

  // reset asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  fdl_cfg_regs #(
    .N_ALGO (N_ALGO),
    .PS_W   (PS_W),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mask_o    (mask_w),
    .veto_o    (veto_w),
    .factor_o  (factor_w),
    .ps_load_o (ps_load_w),
    .cnt_clr_o (cnt_clr_w)
  );

  for (genvar g = 0; g < N_ALGO; g++) begin : g_algo
    fdl_prescaler #(.PS_W(PS_W)) u_ps (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .hit_i    (algo_bits[g]),
      .factor_i (factor_w[g]),
      .load_i   (ps_load_w[g]),
      .pass_o   (pass_w[g])
    );
    fdl_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .hit_i   (algo_bits[g]),
      .clr_i   (cnt_clr_w),
      .count_o (cnt_w[g])
    );
  end

  always_comb begin
    or_hit   = |(pass_w & mask_w);
    veto_hit = |(algo_bits & veto_w);
    accept_d = or_hit & ~veto_hit;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      accept_q <= 1'b0;
    end else begin
      accept_q <= accept_d;
    end
  end
  assign accept = accept_q;

  always_comb begin
    if ({1'b0, cnt_sel} < (IDX_W+1)'(N_ALGO)) begin
      cnt_value = cnt_w[cnt_sel];
    end else begin
      cnt_value = '0;
    end
  end

endmodule

// File: rtl/fdl_checker.sv
module fdl_checker #(
  parameter int N_ALGO = 128,
  parameter int PS_W   = 8,
  parameter int CNT_W  = 16
) (
  input logic                          clk,
  input logic                          rst_ok,
  input logic [N_ALGO-1:0]             algo_bits,
  input logic [N_ALGO-1:0]             mask,
  input logic [N_ALGO-1:0]             veto,
  input logic [N_ALGO-1:0][PS_W-1:0]   factor,
  input logic [N_ALGO-1:0]             pass,
  input logic                          cnt_clr,
  input logic [N_ALGO-1:0][CNT_W-1:0]  cnt_arr,
  input logic                          accept
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_idle_no_accept_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (algo_bits == '0) |=> !accept);

  assert_mask_gates_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    ((pass & mask) == '0) |=> !accept);

  assert_veto_blocks_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    ((algo_bits & veto) != '0) |=> !accept);

  for (genvar i = 0; i < N_ALGO; i++) begin : g_bit
    assert_pass_needs_hit_R5: assert property (@(posedge clk) disable iff (!rst_ok)
      pass[i] |-> algo_bits[i]);

    assert_zero_factor_R6: assert property (@(posedge clk) disable iff (!rst_ok)
      (factor[i] == '0) |-> !pass[i]);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_ok)
      (!cnt_clr && algo_bits[i] && cnt_arr[i] != CNT_MAX)
        |=> cnt_arr[i] == CNT_W'($past(cnt_arr[i]) + 1'b1));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_ok)
      (!cnt_clr && cnt_arr[i] == CNT_MAX) |=> cnt_arr[i] == CNT_MAX);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_ok)
      cnt_clr |=> cnt_arr[i] == '0);
  end

endmodule

bind trig_final_decision fdl_checker #(
  .N_ALGO (N_ALGO),
  .PS_W   (PS_W),
  .CNT_W  (CNT_W)
) u_fdl_checker (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .algo_bits (algo_bits),
  .mask      (mask_w),
  .veto      (veto_w),
  .factor    (factor_w),
  .pass      (pass_w),
  .cnt_clr   (cnt_clr_w),
  .cnt_arr   (cnt_w),
  .accept    (accept)
);

// File: tb/test_trig_final_decision.sv
module test_trig_final_decision;

  localparam int NA = 40;
  localparam int PW = 4;
  localparam int CW = 4;
  localparam int IW = $clog2(NA);
  localparam int AW = IW + 2;

  localparam logic [NA-1:0] B0  = 40'h00_0000_0001;
  localparam logic [NA-1:0] B1  = 40'h00_0000_0002;
  localparam logic [NA-1:0] B2  = 40'h00_0000_0004;
  localparam logic [NA-1:0] B3  = 40'h00_0000_0008;
  localparam logic [NA-1:0] B5  = 40'h00_0000_0020;
  localparam logic [NA-1:0] B7  = 40'h00_0000_0080;
  localparam logic [NA-1:0] B33 = 40'h02_0000_0000;
  localparam logic [NA-1:0] B38 = 40'h40_0000_0000;

  // {algo pattern, expected accept}; mask = 0,5,33, veto = 7,38, factors 1
  localparam logic [NA:0] VECS [0:8] = '{
    {40'h0,       1'b0},
    {B0,          1'b1},
    {B1,          1'b0},
    {B33,         1'b1},
    {B0 | B7,     1'b0},
    {B5 | B38,    1'b0},
    {B38,         1'b0},
    {B5 | B1,     1'b1},
    {B33 | B0,    1'b1}
  };

  logic          clk;
  logic          rst_n;
  logic [NA-1:0] algo_bits;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic [IW-1:0] cnt_sel;
  logic [CW-1:0] cnt_value;
  logic          accept;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  trig_final_decision #(.N_ALGO(NA), .PS_W(PW), .CNT_W(CW)) i_trig_final_decision (
    .clk       (clk),
    .rst_n     (rst_n),
    .algo_bits (algo_bits),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cnt_sel   (cnt_sel),
    .cnt_value (cnt_value),
    .accept    (accept)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    algo_bits = '0;
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic cyc(input logic [NA-1:0] a, input logic exp, input string tag);
    @(negedge clk);
    algo_bits = a;
    @(posedge clk);
    #2;
    check(tag, {31'b0, accept}, {31'b0, exp});
  endtask

  task automatic put(input logic [NA-1:0] a);
    @(negedge clk);
    algo_bits = a;
    @(posedge clk);
    #2;
  endtask

  task automatic read_cnt(input int sel, input int exp, input string tag);
    @(negedge clk);
    algo_bits = '0;
    cnt_sel   = IW'(sel);
    #1;
    check(tag, 32'(cnt_value), 32'(exp));
  endtask

  function automatic logic [AW-1:0] addr(input int region, input int idx);
    return AW'((region << IW) | idx);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; algo_bits = '0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; cnt_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1 check("R1 accept after reset", {31'b0, accept}, 32'd0);
    read_cnt(0,  0, "R1 counter 0 after reset");
    read_cnt(39, 0, "R1 counter 39 after reset");
    cyc(B0, 1'b0, "R1 mask clear after reset");
    cfg_write(addr(0, 0), 32'h0000_0021);
    cyc(B0, 1'b1, "R1 default factor one");

    cfg_write(addr(0, 1), 32'h0000_0002);
    cfg_write(addr(1, 0), 32'h0000_0080);
    cfg_write(addr(1, 1), 32'h0000_0040);

    // R3 R4 vector table
    for (int k = 0; k < 9; k++) begin
      cyc(VECS[k][NA:1], VECS[k][0], $sformatf("R3/R4 table entry %0d", k));
    end

    // R2 latency
    @(negedge clk);
    algo_bits = '0;
    @(negedge clk);
    algo_bits = B0;
    #2 check("R2 no accept before edge", {31'b0, accept}, 32'd0);
    @(posedge clk);
    #2 check("R2 accept one edge later", {31'b0, accept}, 32'd1);
    cyc('0, 1'b0, "R2 accept drops after idle edge");

    // R5 prescale by 3, back to back and with gaps
    cfg_write(addr(2, 0), 32'd3);
    cyc(B0, 1'b0, "R5 ps3 occ1");
    cyc(B0, 1'b0, "R5 ps3 occ2");
    cyc(B0, 1'b1, "R5 ps3 occ3");
    cyc(B0, 1'b0, "R5 ps3 occ4");
    cyc(B0, 1'b0, "R5 ps3 occ5");
    cyc(B0, 1'b1, "R5 ps3 occ6");
    cyc(B0, 1'b0, "R5 gap occ1");
    cyc('0, 1'b0, "R5 gap idle");
    cyc(B0, 1'b0, "R5 gap occ2");
    cyc('0, 1'b0, "R5 gap idle");
    cyc(B0, 1'b1, "R5 gap occ3");

    // R5 factor rewrite restarts the count
    cfg_write(addr(2, 0), 32'd2);
    cyc(B0, 1'b0, "R5 ps2 first");
    cfg_write(addr(2, 0), 32'd2);
    cyc(B0, 1'b0, "R5 ps2 after rewrite occ1");
    cyc(B0, 1'b1, "R5 ps2 after rewrite occ2");

    // R6 factor zero, R7 raw counting
    cfg_write(addr(3, 0), 32'd0);
    cfg_write(addr(2, 0), 32'd0);
    for (int k = 0; k < 4; k++) cyc(B0, 1'b0, "R6 factor zero blocks");
    read_cnt(0, 4, "R7 raw count with factor zero");
    for (int k = 0; k < 3; k++) cyc(B1, 1'b0, "R3 unmasked bit");
    read_cnt(1, 3, "R7 count on unmasked bit");

    // R4 veto on raw bit even with factor zero
    cfg_write(addr(2, 7), 32'd0);
    cyc(B5 | B7, 1'b0, "R4 veto with factor zero");
    cyc(B5, 1'b1, "R4 no veto");

    // R8 saturation
    cfg_write(addr(3, 0), 32'd0);
    for (int k = 0; k < 20; k++) put(B3);
    read_cnt(3, 15, "R8 saturate at max");
    read_cnt(2, 0,  "R7 neighbour untouched");

    // R9 clear, also with same-edge occurrence
    cfg_write(addr(3, 0), 32'd0);
    read_cnt(3, 0, "R9 clear");
    put(B3);
    put(B3);
    @(negedge clk);
    algo_bits = B3; cfg_we = 1'b1; cfg_addr = addr(3, 0); cfg_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0; algo_bits = '0;
    read_cnt(3, 0, "R9 clear wins over occurrence");

    // R10 read select
    put(B2);
    read_cnt(2,  1, "R10 read selected counter");
    read_cnt(45, 0, "R10 out of range select");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule